// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the status and interrupt flags of a synchronous serial port. In that port a transmit buffer feeds a transmit shifter, and a receive shifter feeds a receive buffer. The data path reports single-cycle event strobes to the block:

- a word written to the transmit buffer;
- the transmit shifter loaded, and the transmit shifter drained;
- the receive buffer loaded, and the receive buffer read;
- a receive shift completed;
- a receive frame sync seen;
- a read of the status word.

From these strobes the block derives:

- the receive-ready and transmit-ready flags;
- a flag that shows the transmit shifter holds data;
- a receiver overrun flag;
- sticky receive and transmit interrupt flags;
- the direction control for the transmit frame-sync pin.

The two ready flags follow their loading events after a fixed latency. The latency is set by a parameter and defaults to three clocks. A load that arrives while the latency is still running starts the count again.

Overrun detection depends on the framing mode. In continuous framing, overrun is flagged as soon as both the receive shifter and the receive buffer hold unread data. In framed (noncontinuous) operation, overrun is flagged only when a new receive frame sync arrives while both are full. When a status read and a new overrun occur in the same cycle, the new overrun wins.

The global reset is asynchronous and active low. The separate transmit and receive resets are synchronous and each clears only its own half. All the flags are also packed into one status word for the host.

Top module: `sp_flag_ctrl`

## Requirements
- R1: `rrdy_o` rises on the third rising clock edge after the edge that samples `rbuf_load_i` (RDY_DLY edges in general). A new `rbuf_load_i` during that wait restarts the count.
- R2: `rrdy_o` is cleared by `rbuf_rd_i`, by `rcv_rst_i` and by the global reset. When the delayed set and `rbuf_rd_i` fall in the same cycle, `rrdy_o` ends up 1.
- R3: `xrdy_o` clears on `xbuf_wr_i`, and that write wins over a coincident delayed set. `xrdy_o` rises RDY_DLY edges after `xsh_load_i`, and a new load during the wait restarts the count.
- R4: `xsr_busy_o` is 1 while the transmit shifter holds data. It is set by `xsh_load_i` and cleared by `xsh_done_i`; a load wins over a coincident drain. `xmt_rst_i` or the global reset forces it to 0.
- R5: With `cont_mode_i` = 1, `rovr_o` sets on the edge after the cycle in which both the receive shifter and the receive buffer are full. The shifter is full from `rsh_full_i` until `rbuf_load_i`. The buffer is full from `rbuf_load_i` until `rbuf_rd_i`.
- R6: With `cont_mode_i` = 0, `rovr_o` sets only when `rfs_i` is 1 in a cycle where both are full.
- R7: Only `stat_rd_i`, `rcv_rst_i` or the global reset clears `rovr_o`. A set condition in the same cycle as `stat_rd_i` leaves it at 1.
- R8: `rint_o` and `xint_o` set one edge after a rising edge of `rrdy_o` or `xrdy_o`. They stay set until `rint_clr_i` or `xint_clr_i` arrives; a new rising edge wins over a coincident clear. The receive reset clears `rint_o` and the transmit reset clears `xint_o`. `xmt_rst_i` raises `xrdy_o` without setting `xint_o`.
- R9: `fsx_oe_o` (0 = pin is an input, 1 = pin is an output) loads `fsx_dir_val_i` on `fsx_dir_wr_i` and is 0 after global reset.
- R10: The layout of `stat_o` is as follows. Every other bit reads 0.

  | Bit | Flag |
  |---|---|
  | 0 | rrdy |
  | 1 | xrdy |
  | 2 | fsx_oe |
  | 3 | xsr_busy |
  | 4 | rovr |
  | 5 | rint |
  | 6 | xint |

- R11: After global reset, `xrdy_o` is 1 and every other flag is 0, so `stat_o` equals 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| cont_mode_i | input | 1 | 1 = continuous framing, 0 = framed |
| xmt_rst_i | input | 1 | Synchronous transmit-side reset |
| rcv_rst_i | input | 1 | Synchronous receive-side reset |
| xbuf_wr_i | input | 1 | Word written to transmit buffer |
| xsh_load_i | input | 1 | Transmit shifter loaded |
| xsh_done_i | input | 1 | Transmit shifter drained |
| rbuf_load_i | input | 1 | Receive buffer loaded |
| rbuf_rd_i | input | 1 | Receive buffer read |
| rsh_full_i | input | 1 | Receive shift completed |
| rfs_i | input | 1 | Receive frame sync seen |
| stat_rd_i | input | 1 | Status word read |
| rint_clr_i | input | 1 | Clear receive interrupt |
| xint_clr_i | input | 1 | Clear transmit interrupt |
| fsx_dir_wr_i | input | 1 | Write strobe for frame-sync direction |
| fsx_dir_val_i | input | 1 | Frame-sync direction value |
| rrdy_o | output | 1 | Receive ready |
| xrdy_o | output | 1 | Transmit ready |
| xsr_busy_o | output | 1 | Transmit shifter holds data |
| rovr_o | output | 1 | Receiver overrun |
| rint_o | output | 1 | Receive interrupt flag |
| xint_o | output | 1 | Transmit interrupt flag |
| fsx_oe_o | output | 1 | Frame-sync pin drive enable |
| stat_o | output | STAT_W | Packed status word |

## Verification
A miscounting delay counter shows up on `rrdy_o` or `xrdy_o` one edge early or late. A wrong edge-detect register shows as a missing or spurious interrupt one edge after the ready flag changes. A lost shifter-full or buffer-full state is harder to see, because it stays invisible until the next overrun opportunity. That opportunity is immediate in continuous mode, but in framed mode it waits for the next frame sync. A wrong priority between a set and a read or clear appears only in the cycle where both coincide, so such collisions are forced both directed and at random.

// File: rtl/sp_flag_pkg.sv
package sp_flag_pkg;

    // Bit positions inside the packed status word.
    localparam int unsigned ST_RRDY  = 0;
    localparam int unsigned ST_XRDY  = 1;
    localparam int unsigned ST_FSXO  = 2;
    localparam int unsigned ST_XBUSY = 3;
    localparam int unsigned ST_ROVR  = 4;
    localparam int unsigned ST_RINT  = 5;
    localparam int unsigned ST_XINT  = 6;
    localparam int unsigned ST_USED  = 7;

    typedef struct packed {
        logic rrdy;
        logic xrdy;
        logic fsx_oe;
        logic xbusy;
        logic rovr;
        logic rint;
        logic xint;
    } sp_flags_t;

endpackage

// File: rtl/sp_ready_delay.sv
module sp_ready_delay #(
    parameter int unsigned DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cancel_i,
    input  logic load_i,
    output logic done_o
);
    localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] START = CW'(DLY - 1);

    typedef struct packed {
        logic          pend;
        logic [CW-1:0] cnt;
    } dly_t;

    dly_t d, q;
    logic          pend_w;
    logic [CW-1:0] cnt_w;

    assign pend_w = q.pend;
    assign cnt_w  = q.cnt;
    // The count ends this cycle unless a restart or cancel arrives now.
    assign done_o = q.pend && (q.cnt == '0) && !load_i && !cancel_i;

    always_comb begin
        d = q;
        if (cancel_i) begin
            d = '0;
        end else if (load_i) begin
            d.pend = 1'b1;
            d.cnt  = START;
        end else if (done_o) begin
            d.pend = 1'b0;
        end else if (q.pend) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1
    count_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && (cnt_w != '0) && !load_i && !cancel_i)
        |=> (pend_w && (cnt_w == $past(cnt_w) - 1'b1)));

    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !cancel_i) |=> (pend_w && (cnt_w == START)));

endmodule

// File: rtl/sp_rx_flags.sv
module sp_rx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rcv_rst_i,
    input  logic cont_i,
    input  logic rbuf_load_i,
    input  logic rbuf_rd_i,
    input  logic rsh_full_i,
    input  logic rfs_i,
    input  logic stat_rd_i,
    input  logic rint_clr_i,
    input  logic ready_set_i,
    output logic rrdy_o,
    output logic rovr_o,
    output logic rint_o
);
    typedef struct packed {
        logic rrdy;
        logic rrdy_p;
        logic rbuf_full;
        logic rsr_full;
        logic ovr;
        logic rint;
    } rx_t;

    rx_t  d, q;
    logic ovr_hit;
    logic rsr_full_w, rbuf_full_w;

    assign rsr_full_w  = q.rsr_full;
    assign rbuf_full_w = q.rbuf_full;
    // Framed mode waits for a new frame sync before flagging the collision.
    assign ovr_hit = q.rsr_full && q.rbuf_full && (cont_i || rfs_i);

    always_comb begin
        d        = q;
        d.rrdy_p = q.rrdy;

        if (ready_set_i)    d.rrdy = 1'b1;
        else if (rbuf_rd_i) d.rrdy = 1'b0;

        if (rbuf_load_i)    d.rbuf_full = 1'b1;
        else if (rbuf_rd_i) d.rbuf_full = 1'b0;

        if (rsh_full_i)       d.rsr_full = 1'b1;
        else if (rbuf_load_i) d.rsr_full = 1'b0;

        if (ovr_hit)        d.ovr = 1'b1;
        else if (stat_rd_i) d.ovr = 1'b0;

        if (q.rrdy && !q.rrdy_p) d.rint = 1'b1;
        else if (rint_clr_i)     d.rint = 1'b0;

        if (rcv_rst_i) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rrdy_o = q.rrdy;
    assign rovr_o = q.ovr;
    assign rint_o = q.rint;

    // R2
    rd_clears_rrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rbuf_rd_i && !ready_set_i && !rcv_rst_i) |=> !rrdy_o);

    // R5
    cont_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_i && rsr_full_w && rbuf_full_w && !rcv_rst_i) |=> rovr_o);

    // R7
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rovr_o && !stat_rd_i && !rcv_rst_i) |=> rovr_o);

    // R8
    rint_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rrdy_o) && !rcv_rst_i) |=> rint_o);

endmodule

// File: rtl/sp_tx_flags.sv
module sp_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic xmt_rst_i,
    input  logic xbuf_wr_i,
    input  logic xsh_load_i,
    input  logic xsh_done_i,
    input  logic xint_clr_i,
    input  logic ready_set_i,
    output logic xrdy_o,
    output logic xsr_busy_o,
    output logic xint_o
);
    typedef struct packed {
        logic xrdy;
        logic xrdy_p;
        logic busy;
        logic xint;
    } tx_t;

    localparam tx_t TX_RST = '{xrdy: 1'b1, xrdy_p: 1'b1, busy: 1'b0, xint: 1'b0};

    tx_t d, q;

    always_comb begin
        d        = q;
        d.xrdy_p = q.xrdy;

        // A pending word keeps the buffer not-ready even if the delay ends now.
        if (xbuf_wr_i)        d.xrdy = 1'b0;
        else if (ready_set_i) d.xrdy = 1'b1;

        if (xsh_load_i)      d.busy = 1'b1;
        else if (xsh_done_i) d.busy = 1'b0;

        if (q.xrdy && !q.xrdy_p) d.xint = 1'b1;
        else if (xint_clr_i)     d.xint = 1'b0;

        if (xmt_rst_i) d = TX_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RST;
        else        q <= d;
    end

    assign xrdy_o     = q.xrdy;
    assign xsr_busy_o = q.busy;
    assign xint_o     = q.xint;

    // R3
    wr_drops_xrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xbuf_wr_i && !xmt_rst_i) |=> !xrdy_o);

    // R4
    load_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xsh_load_i && !xmt_rst_i) |=> xsr_busy_o);

    // R4
    xrst_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xmt_rst_i |=> (!xsr_busy_o && xrdy_o && !xint_o));

endmodule

// File: rtl/sp_flag_ctrl.sv
module sp_flag_ctrl
    import sp_flag_pkg::*;
#(
    parameter int unsigned RDY_DLY = 3,
    parameter int unsigned STAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cont_mode_i,
    input  logic              xmt_rst_i,
    input  logic              rcv_rst_i,
    input  logic              xbuf_wr_i,
    input  logic              xsh_load_i,
    input  logic              xsh_done_i,
    input  logic              rbuf_load_i,
    input  logic              rbuf_rd_i,
    input  logic              rsh_full_i,
    input  logic              rfs_i,
    input  logic              stat_rd_i,
    input  logic              rint_clr_i,
    input  logic              xint_clr_i,
    input  logic              fsx_dir_wr_i,
    input  logic              fsx_dir_val_i,
    output logic              rrdy_o,
    output logic              xrdy_o,
    output logic              xsr_busy_o,
    output logic              rovr_o,
    output logic              rint_o,
    output logic              xint_o,
    output logic              fsx_oe_o,
    output logic [STAT_W-1:0] stat_o
);
    localparam int unsigned NCH    = 2;
    localparam int unsigned CH_TX  = 0;
    localparam int unsigned CH_RX  = 1;

    logic [NCH-1:0] dly_load, dly_cancel, dly_done;
    logic           fsx_d, fsx_q;
    sp_flags_t      flags;

    assign dly_load[CH_TX]   = xsh_load_i;
    assign dly_load[CH_RX]   = rbuf_load_i;
    assign dly_cancel[CH_TX] = xmt_rst_i;
    assign dly_cancel[CH_RX] = rcv_rst_i;

    for (genvar c = 0; c < NCH; c++) begin : g_dly
        sp_ready_delay #(.DLY(RDY_DLY)) u_dly (
            .clk      (clk),
            .rst_n    (rst_n),
            .cancel_i (dly_cancel[c]),
            .load_i   (dly_load[c]),
            .done_o   (dly_done[c])
        );
    end

    sp_rx_flags u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rcv_rst_i   (rcv_rst_i),
        .cont_i      (cont_mode_i),
        .rbuf_load_i (rbuf_load_i),
        .rbuf_rd_i   (rbuf_rd_i),
        .rsh_full_i  (rsh_full_i),
        .rfs_i       (rfs_i),
        .stat_rd_i   (stat_rd_i),
        .rint_clr_i  (rint_clr_i),
        .ready_set_i (dly_done[CH_RX]),
        .rrdy_o      (rrdy_o),
        .rovr_o      (rovr_o),
        .rint_o      (rint_o)
    );

    sp_tx_flags u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .xmt_rst_i   (xmt_rst_i),
        .xbuf_wr_i   (xbuf_wr_i),
        .xsh_load_i  (xsh_load_i),
        .xsh_done_i  (xsh_done_i),
        .xint_clr_i  (xint_clr_i),
        .ready_set_i (dly_done[CH_TX]),
        .xrdy_o      (xrdy_o),
        .xsr_busy_o  (xsr_busy_o),
        .xint_o      (xint_o)
    );

    always_comb begin
        fsx_d = fsx_q;
        if (fsx_dir_wr_i) fsx_d = fsx_dir_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsx_q <= 1'b0;
        else        fsx_q <= fsx_d;
    end

    assign fsx_oe_o = fsx_q;

    always_comb begin
        flags.rrdy   = rrdy_o;
        flags.xrdy   = xrdy_o;
        flags.fsx_oe = fsx_q;
        flags.xbusy  = xsr_busy_o;
        flags.rovr   = rovr_o;
        flags.rint   = rint_o;
        flags.xint   = xint_o;
    end

    assign stat_o[ST_RRDY]  = flags.rrdy;
    assign stat_o[ST_XRDY]  = flags.xrdy;
    assign stat_o[ST_FSXO]  = flags.fsx_oe;
    assign stat_o[ST_XBUSY] = flags.xbusy;
    assign stat_o[ST_ROVR]  = flags.rovr;
    assign stat_o[ST_RINT]  = flags.rint;
    assign stat_o[ST_XINT]  = flags.xint;

    for (genvar g = ST_USED; g < STAT_W; g++) begin : g_rsv
        assign stat_o[g] = 1'b0;
    end

    // R9
    fsx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsx_dir_wr_i |=> (fsx_oe_o == $past(fsx_dir_val_i)));

    // R7
    ovr_only_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rovr_o) |-> ($past(stat_rd_i) || $past(rcv_rst_i)));

endmodule

// File: tb/tb_sp_flag_ctrl.sv
`timescale 1ns/1ps
module tb_sp_flag_ctrl;
    localparam int DLY = 3;
    localparam int SW  = 16;

    localparam int EV_XWR  = 0;
    localparam int EV_XLD  = 1;
    localparam int EV_XDN  = 2;
    localparam int EV_RLD  = 3;
    localparam int EV_RRD  = 4;
    localparam int EV_RSH  = 5;
    localparam int EV_RFS  = 6;
    localparam int EV_SRD  = 7;
    localparam int EV_RCLR = 8;
    localparam int EV_XCLR = 9;
    localparam int EV_FWR  = 10;
    localparam int EV_FVAL = 11;
    localparam int EV_XRST = 12;
    localparam int EV_RRST = 13;
    localparam int EV_GRST = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cont = 1'b1;
    logic [14:0] ev = '0;
    logic rrdy, xrdy, xbusy, rovr, rint, xint, fsxo;
    logic [SW-1:0] stat;

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit m_rp, m_rrdy, m_rprev, m_rbf, m_rsf, m_ovr, m_rint;
    int m_rc;
    bit m_xp, m_xrdy, m_xprev, m_busy, m_xint, m_fsx;
    int m_xc;

    always #4 clk = ~clk;

    sp_flag_ctrl #(.RDY_DLY(DLY), .STAT_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .cont_mode_i(cont),
        .xmt_rst_i(ev[EV_XRST]), .rcv_rst_i(ev[EV_RRST]),
        .xbuf_wr_i(ev[EV_XWR]), .xsh_load_i(ev[EV_XLD]), .xsh_done_i(ev[EV_XDN]),
        .rbuf_load_i(ev[EV_RLD]), .rbuf_rd_i(ev[EV_RRD]), .rsh_full_i(ev[EV_RSH]),
        .rfs_i(ev[EV_RFS]), .stat_rd_i(ev[EV_SRD]),
        .rint_clr_i(ev[EV_RCLR]), .xint_clr_i(ev[EV_XCLR]),
        .fsx_dir_wr_i(ev[EV_FWR]), .fsx_dir_val_i(ev[EV_FVAL]),
        .rrdy_o(rrdy), .xrdy_o(xrdy), .xsr_busy_o(xbusy), .rovr_o(rovr),
        .rint_o(rint), .xint_o(xint), .fsx_oe_o(fsxo), .stat_o(stat)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rp = 0; m_rc = 0; m_rrdy = 0; m_rprev = 0; m_rbf = 0; m_rsf = 0;
        m_ovr = 0; m_rint = 0;
        m_xp = 0; m_xc = 0; m_xrdy = 1; m_xprev = 1; m_busy = 0; m_xint = 0;
        m_fsx = 0;
    endtask

    // Status word layout from R10.
    function automatic logic [SW-1:0] exp_stat();
        logic [SW-1:0] s;
        s = '0;
        s[0] = m_rrdy; s[1] = m_xrdy; s[2] = m_fsx; s[3] = m_busy;
        s[4] = m_ovr;  s[5] = m_rint; s[6] = m_xint;
        return s;
    endfunction

    task automatic model_next();
        bit rdone, xdone, hit;
        bit n_rp, n_rrdy, n_rbf, n_rsf, n_ovr, n_rint;
        int n_rc;
        bit n_xp, n_xrdy, n_busy, n_xint;
        int n_xc;
        if (ev[EV_GRST]) begin
            model_reset();
            return;
        end
        rdone = m_rp && (m_rc == 0) && !ev[EV_RLD] && !ev[EV_RRST];
        xdone = m_xp && (m_xc == 0) && !ev[EV_XLD] && !ev[EV_XRST];
        // receive side
        n_rp = m_rp; n_rc = m_rc;
        if (ev[EV_RLD]) begin n_rp = 1; n_rc = DLY - 1; end
        else if (rdone) n_rp = 0;
        else if (m_rp) n_rc = m_rc - 1;
        n_rrdy = rdone ? 1'b1 : (ev[EV_RRD] ? 1'b0 : m_rrdy);
        n_rbf  = ev[EV_RLD] ? 1'b1 : (ev[EV_RRD] ? 1'b0 : m_rbf);
        n_rsf  = ev[EV_RSH] ? 1'b1 : (ev[EV_RLD] ? 1'b0 : m_rsf);
        hit    = m_rsf && m_rbf && (cont || ev[EV_RFS]);
        n_ovr  = hit ? 1'b1 : (ev[EV_SRD] ? 1'b0 : m_ovr);
        n_rint = (m_rrdy && !m_rprev) ? 1'b1 : (ev[EV_RCLR] ? 1'b0 : m_rint);
        // transmit side
        n_xp = m_xp; n_xc = m_xc;
        if (ev[EV_XLD]) begin n_xp = 1; n_xc = DLY - 1; end
        else if (xdone) n_xp = 0;
        else if (m_xp) n_xc = m_xc - 1;
        n_xrdy = ev[EV_XWR] ? 1'b0 : (xdone ? 1'b1 : m_xrdy);
        n_busy = ev[EV_XLD] ? 1'b1 : (ev[EV_XDN] ? 1'b0 : m_busy);
        n_xint = (m_xrdy && !m_xprev) ? 1'b1 : (ev[EV_XCLR] ? 1'b0 : m_xint);
        if (ev[EV_FWR]) m_fsx = ev[EV_FVAL];
        if (ev[EV_RRST]) begin
            m_rp = 0; m_rc = 0; m_rrdy = 0; m_rprev = 0; m_rbf = 0; m_rsf = 0;
            m_ovr = 0; m_rint = 0;
        end else begin
            m_rprev = m_rrdy;
            m_rp = n_rp; m_rc = n_rc; m_rrdy = n_rrdy; m_rbf = n_rbf;
            m_rsf = n_rsf; m_ovr = n_ovr; m_rint = n_rint;
        end
        if (ev[EV_XRST]) begin
            m_xp = 0; m_xc = 0; m_xrdy = 1; m_xprev = 1; m_busy = 0; m_xint = 0;
        end else begin
            m_xprev = m_xrdy;
            m_xp = n_xp; m_xc = n_xc; m_xrdy = n_xrdy; m_busy = n_busy; m_xint = n_xint;
        end
    endtask

    task automatic compare_all();
        chk("R1", "rrdy", 32'(rrdy), 32'(m_rrdy));
        chk("R3", "xrdy", 32'(xrdy), 32'(m_xrdy));
        chk("R4", "xsr_busy", 32'(xbusy), 32'(m_busy));
        chk(cont ? "R5" : "R6", "rovr", 32'(rovr), 32'(m_ovr));
        chk("R8", "rint", 32'(rint), 32'(m_rint));
        chk("R8", "xint", 32'(xint), 32'(m_xint));
        chk("R9", "fsx_oe", 32'(fsxo), 32'(m_fsx));
        chk("R10", "stat", 32'(stat), 32'(exp_stat()));
    endtask

    // Drive one cycle of events at the falling edge, then sample after the rising edge.
    task automatic step(input logic [14:0] e);
        @(negedge clk);
        ev    = e;
        rst_n = !e[EV_GRST];
        model_next();
        @(posedge clk);
        #2;
        compare_all();
    endtask

    function automatic logic [14:0] b(input int i);
        return 15'(1) << i;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11", "stat after reset", 32'(stat), 32'h0002);
        chk("R11", "xrdy after reset", 32'(xrdy), 32'd1);

        // R1 basic latency
        step(b(EV_RLD));
        step('0); step('0);
        chk("R1", "rrdy two edges after load", 32'(rrdy), 32'd0);
        step('0);
        chk("R1", "rrdy three edges after load", 32'(rrdy), 32'd1);
        step('0);
        chk("R8", "rint after rrdy rise", 32'(rint), 32'd1);
        step(b(EV_RCLR));
        chk("R8", "rint cleared", 32'(rint), 32'd0);
        // R2 read clears
        step(b(EV_RRD));
        chk("R2", "rrdy after read", 32'(rrdy), 32'd0);
        // R1 restart
        step(b(EV_RLD)); step('0); step(b(EV_RLD)); step('0); step('0);
        chk("R1", "rrdy held by restart", 32'(rrdy), 32'd0);
        step('0);
        chk("R1", "rrdy after restarted wait", 32'(rrdy), 32'd1);
        // R2 set wins over read
        step(b(EV_RRD));
        step(b(EV_RLD)); step('0); step('0); step(b(EV_RRD));
        chk("R2", "set beats read", 32'(rrdy), 32'd1);
        step(b(EV_RRD));
        step(b(EV_RRST));
        chk("R2", "rrdy after receive reset", 32'(rrdy), 32'd0);

        // R5 continuous overrun
        cont = 1'b1;
        step(b(EV_RLD)); step(b(EV_RSH));
        chk("R5", "no overrun yet", 32'(rovr), 32'd0);
        step('0);
        chk("R5", "overrun both full", 32'(rovr), 32'd1);
        // R7 set wins over read, then read clears
        step(b(EV_SRD));
        chk("R7", "set beats status read", 32'(rovr), 32'd1);
        step(b(EV_RRD));
        chk("R7", "buffer read does not clear", 32'(rovr), 32'd1);
        step(b(EV_SRD));
        chk("R7", "status read clears", 32'(rovr), 32'd0);

        // R6 framed overrun needs frame sync
        step(b(EV_RRST));
        cont = 1'b0;
        step(b(EV_RLD)); step(b(EV_RSH)); step('0); step('0);
        chk("R6", "no overrun without sync", 32'(rovr), 32'd0);
        step(b(EV_RFS));
        chk("R6", "overrun on sync", 32'(rovr), 32'd1);
        step(b(EV_RRST));
        chk("R7", "receive reset clears", 32'(rovr), 32'd0);
        cont = 1'b1;

        // R3 / R4 transmit side
        step(b(EV_XWR));
        chk("R3", "xrdy drops on write", 32'(xrdy), 32'd0);
        step(b(EV_XLD));
        chk("R4", "busy after load", 32'(xbusy), 32'd1);
        step('0); step('0);
        chk("R3", "xrdy still low", 32'(xrdy), 32'd0);
        step('0);
        chk("R3", "xrdy after delay", 32'(xrdy), 32'd1);
        step('0);
        chk("R8", "xint after xrdy rise", 32'(xint), 32'd1);
        step(b(EV_XDN));
        chk("R4", "busy cleared by drain", 32'(xbusy), 32'd0);
        step(b(EV_XCLR));
        chk("R8", "xint cleared", 32'(xint), 32'd0);
        step(b(EV_XWR)); step(b(EV_XLD)); step('0); step('0); step(b(EV_XWR));
        chk("R3", "write beats delayed set", 32'(xrdy), 32'd0);
        step(b(EV_XLD));
        step(b(EV_XRST));
        chk("R4", "transmit reset empties", 32'(xbusy), 32'd0);
        chk("R3", "transmit reset raises xrdy", 32'(xrdy), 32'd1);
        step('0);
        chk("R8", "no xint from transmit reset", 32'(xint), 32'd0);

        // R9 / R10 direction bit and layout
        step(b(EV_FWR) | b(EV_FVAL));
        chk("R9", "fsx output", 32'(fsxo), 32'd1);
        chk("R10", "stat bit 2", 32'(stat[2]), 32'd1);
        chk("R10", "reserved bits", 32'(stat[SW-1:7]), 32'd0);
        step(b(EV_FWR));
        chk("R9", "fsx input", 32'(fsxo), 32'd0);

        // R11 mid-run global reset
        step(b(EV_XWR) | b(EV_FWR) | b(EV_FVAL));
        step(b(EV_GRST));
        chk("R11", "stat after global reset", 32'(stat), 32'h0002);

        // Random phase against the model
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            logic [14:0] e;
            if ((i % 250) == 0) cont = 1'($urandom_range(0, 1));
            e = '0;
            e[EV_XWR]  = ($urandom_range(0, 7) == 0);
            e[EV_XLD]  = ($urandom_range(0, 6) == 0);
            e[EV_XDN]  = ($urandom_range(0, 5) == 0);
            e[EV_RLD]  = ($urandom_range(0, 6) == 0);
            e[EV_RRD]  = ($urandom_range(0, 7) == 0);
            e[EV_RSH]  = ($urandom_range(0, 5) == 0);
            e[EV_RFS]  = ($urandom_range(0, 4) == 0);
            e[EV_SRD]  = ($urandom_range(0, 7) == 0);
            e[EV_RCLR] = ($urandom_range(0, 9) == 0);
            e[EV_XCLR] = ($urandom_range(0, 9) == 0);
            e[EV_FWR]  = ($urandom_range(0, 19) == 0);
            e[EV_FVAL] = 1'($urandom_range(0, 1));
            e[EV_XRST] = ($urandom_range(0, 79) == 0);
            e[EV_RRST] = ($urandom_range(0, 79) == 0);
            e[EV_GRST] = ($urandom_range(0, 499) == 0);
            step(e);
        end
        step('0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule